// File: doc/BRIEF.md
# Zero-Skipping Sparse Line Multiply-Accumulate

This block takes activation values one at a time over a valid/ready stream, grouped into feature-map lines of up to `N` positions. While a line arrives, an encoder builds a presence bitmap with one bit per position and a packed list holding only the nonzero values, in arrival order. It also keeps a count of those nonzero values. Zeros are dropped at the input and never written anywhere.

When a line is complete, a compute engine works directly on the compressed form. It never rebuilds the dense line. In each cycle it finds the lowest remaining set bit of the bitmap, multiplies the next packed value by the weight at that position, and shifts the bitmap and the weight vector past that bit. It runs for exactly as many cycles as the stored count. Zero positions therefore cost no multiply cycles. The line's weights come in on a flat per-position vector. The 24-bit signed sum is reported with a one-cycle done pulse, together with the line's bitmap and count.

The encoder has two states. FILL accepts values with `in_ready` high. FILL goes to HOLD when a line ends. HOLD goes back to FILL on the cycle the engine finishes. The engine has two states. IDLE goes to SCAN when the encoder holds a full line, and at that moment the engine loads the bitmap, packed values, count and weights. SCAN stays in SCAN while nonzero values remain. SCAN goes back to IDLE once none remain, which raises `out_done` and releases the encoder.

Top module: `sparse_line_mac`

## Requirements
- R1: In `out_map`, bit i is 1 exactly when the value accepted at position i of the line was nonzero. Position 0 is the first value of the line. Positions that were never received read 0.
- R2: Zero values are not stored. `out_nnz` equals the number of nonzero values in the line.
- R3: `out_sum` equals the sum over all positions i of value(i) × w(i), as a 24-bit signed result. Each value is 8-bit signed. w(i) is the 8-bit signed weight at `line_wts[8i+7:8i]`, sampled on the clock edge after the line's final value is accepted.
- R4: A line ends with the accepted value that has `in_last` high, or with the N-th accepted value, whichever comes first.
- R5: `out_done` rises exactly nnz+2 rising clock edges after the edge that accepts the line's final value. This is one cycle per nonzero value, plus one start cycle, plus the output register.
- R6: `out_done` is high for a single cycle per line. `out_sum`, `out_nnz` and `out_map` are valid while it is high.
- R7: After reset, `in_ready` is 1 and `out_done` is 0. `in_ready` is 0 from the cycle after a line's final accept until `out_done` rises, and it is 1 during the `out_done` cycle.
- R8: A line of all zeros gives sum 0, nnz 0 and map 0, with `out_done` 2 edges after its final accept.
- R9: `in_valid`, `in_data` and `in_last` have no effect while `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Activation value present |
| in_ready | output | 1 | Block can take a value |
| in_data | input | 8 | Signed activation value |
| in_last | input | 1 | Marks the final value of a line |
| line_wts | input | N×8 | Signed weight per position, position i at bits 8i+7:8i |
| out_done | output | 1 | One-cycle result strobe |
| out_sum | output | 24 | Signed accumulated sum of the line |
| out_nnz | output | $clog2(N+1) | Nonzero count of the line |
| out_map | output | N | Presence bitmap of the line |

## Verification
The main function is tried on several kinds of line:
- A full line of zeros shows that the engine skips straight to the result after its start cycle.
- A full line of extreme nonzero values exercises every multiply slot and the accumulator range.
- A single nonzero value at the last position checks the shift across a long run of zeros.
- Lines ended early by `in_last` and full lines ended without it separate the two ways a line can end.
- Random lines of varying density and length, with random weights, are compared against a dense dot product.

For every line the bench checks the result, the count, the bitmap and the exact latency in edges. While a line is busy, it drives nonzero garbage on the input, which must leave the next line unchanged.

// File: rtl/slm_pkg.sv
`timescale 1ns/1ps
package slm_pkg;
    typedef enum logic {
        ENC_FILL,
        ENC_HOLD
    } enc_state_t;

    typedef enum logic {
        ENG_IDLE,
        ENG_SCAN
    } eng_state_t;
endpackage

// File: rtl/slm_encoder.sv
`timescale 1ns/1ps
module slm_encoder
    import slm_pkg::*;
#(
    parameter int N  = 16,
    parameter int VW = 8,
    parameter int CW = $clog2(N + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [VW-1:0]     in_data,
    input  logic              in_last,
    output logic              in_ready,
    input  logic              release_i,
    output logic              full_o,
    output logic [N-1:0]      map_o,
    output logic [N*VW-1:0]   pack_o,
    output logic [CW-1:0]     nnz_o
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    enc_state_t state_q, state_d;
    logic [PW-1:0]   pos_q;
    logic [CW-1:0]   cnt_q;
    logic [N-1:0]    map_q;
    logic [N*VW-1:0] pack_q;
    logic            accept, end_line, nz;

    assign accept   = in_valid && (state_q == ENC_FILL);
    assign nz       = (in_data != '0);
    assign end_line = accept && (in_last || (pos_q == PW'(N - 1)));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ENC_FILL;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENC_FILL: if (end_line)  state_d = ENC_HOLD;
            ENC_HOLD: if (release_i) state_d = ENC_FILL;
        endcase
    end

    // line storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q  <= '0;
            cnt_q  <= '0;
            map_q  <= '0;
            pack_q <= '0;
        end else if (accept) begin
            map_q[pos_q] <= nz;
            pos_q        <= pos_q + 1'b1;
            if (nz) begin
                pack_q[cnt_q*VW +: VW] <= in_data;
                cnt_q                  <= cnt_q + 1'b1;
            end
        end else if (state_q == ENC_HOLD && release_i) begin
            pos_q <= '0;
            cnt_q <= '0;
            map_q <= '0;
        end
    end

    // outputs
    always_comb begin
        in_ready = (state_q == ENC_FILL);
        full_o   = (state_q == ENC_HOLD);
        map_o    = map_q;
        pack_o   = pack_q;
        nnz_o    = cnt_q;
    end

    a_r2_count_matches_map: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENC_HOLD) |-> (cnt_q == CW'($countones(map_q))));

    a_r9_busy_input_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENC_HOLD && !release_i) |=> ($stable(map_q) && $stable(cnt_q)));
endmodule

// File: rtl/slm_engine.sv
`timescale 1ns/1ps
module slm_engine
    import slm_pkg::*;
#(
    parameter int N  = 16,
    parameter int VW = 8,
    parameter int AW = 24,
    parameter int CW = $clog2(N + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [N-1:0]         map_i,
    input  logic [N*VW-1:0]      pack_i,
    input  logic [CW-1:0]        nnz_i,
    input  logic [N*VW-1:0]      wts_i,
    output logic                 finish_o,
    output logic                 done_o,
    output logic signed [AW-1:0] sum_o,
    output logic [CW-1:0]        nnz_o,
    output logic [N-1:0]         map_o
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    eng_state_t state_q, state_d;
    logic [N-1:0]           sh_map;
    logic [N*VW-1:0]        sh_wt, sh_pk, wsel;
    logic [CW-1:0]          left_q, line_nnz;
    logic [N-1:0]           line_map;
    logic signed [AW-1:0]   acc_q;
    logic [PW-1:0]          tz;
    logic [PW:0]            step;
    logic signed [VW-1:0]   x_cur, w_cur;
    logic signed [2*VW-1:0] prod;

    // lowest remaining set bit and its product
    always_comb begin
        tz = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (sh_map[i]) tz = i[PW-1:0];
        end
        step     = {1'b0, tz} + 1'b1;
        wsel     = sh_wt >> (tz * VW);
        w_cur    = signed'(wsel[VW-1:0]);
        x_cur    = signed'(sh_pk[VW-1:0]);
        prod     = x_cur * w_cur;
        finish_o = (state_q == ENG_SCAN) && (left_q == '0);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ENG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENG_IDLE: if (start_i)         state_d = ENG_SCAN;
            ENG_SCAN: if (left_q == '0)    state_d = ENG_IDLE;
        endcase
    end

    // shift-decode datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_map   <= '0;
            sh_wt    <= '0;
            sh_pk    <= '0;
            left_q   <= '0;
            acc_q    <= '0;
            line_map <= '0;
            line_nnz <= '0;
        end else if (state_q == ENG_IDLE && start_i) begin
            sh_map   <= map_i;
            sh_wt    <= wts_i;
            sh_pk    <= pack_i;
            left_q   <= nnz_i;
            acc_q    <= '0;
            line_map <= map_i;
            line_nnz <= nnz_i;
        end else if (state_q == ENG_SCAN && left_q != '0) begin
            acc_q  <= acc_q + AW'(prod);
            sh_map <= sh_map >> step;
            sh_wt  <= sh_wt >> (step * VW);
            sh_pk  <= sh_pk >> VW;
            left_q <= left_q - 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o <= 1'b0;
            sum_o  <= '0;
            nnz_o  <= '0;
            map_o  <= '0;
        end else begin
            done_o <= finish_o;
            if (finish_o) begin
                sum_o <= acc_q;
                nnz_o <= line_nnz;
                map_o <= line_map;
            end
        end
    end

    a_r5_left_tracks_bitmap: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENG_SCAN) |-> (left_q == CW'($countones(sh_map))));

    a_r6_done_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_empty_line_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENG_IDLE && start_i && nnz_i == '0) |=> ##1 done_o);
endmodule

// File: rtl/sparse_line_mac.sv
`timescale 1ns/1ps
module sparse_line_mac #(
    parameter int N  = 16,
    parameter int VW = 8,
    parameter int AW = 24,
    parameter int CW = $clog2(N + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [VW-1:0]        in_data,
    input  logic                 in_last,
    input  logic [N*VW-1:0]      line_wts,
    output logic                 out_done,
    output logic signed [AW-1:0] out_sum,
    output logic [CW-1:0]        out_nnz,
    output logic [N-1:0]         out_map
);
    logic            full, finish;
    logic [N-1:0]    map;
    logic [N*VW-1:0] pack;
    logic [CW-1:0]   nnz;

    slm_encoder #(.N(N), .VW(VW), .CW(CW)) u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_last   (in_last),
        .in_ready  (in_ready),
        .release_i (finish),
        .full_o    (full),
        .map_o     (map),
        .pack_o    (pack),
        .nnz_o     (nnz)
    );

    slm_engine #(.N(N), .VW(VW), .AW(AW), .CW(CW)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (full),
        .map_i    (map),
        .pack_i   (pack),
        .nnz_i    (nnz),
        .wts_i    (line_wts),
        .finish_o (finish),
        .done_o   (out_done),
        .sum_o    (out_sum),
        .nnz_o    (out_nnz),
        .map_o    (out_map)
    );

    a_r7_ready_during_done: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> in_ready);

    a_r7_no_ready_while_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !finish) |=> !out_done || in_ready);
endmodule

// File: tb/sparse_line_mac_bench.sv
`timescale 1ns/1ps
module sparse_line_mac_bench;
    localparam int N  = 16;
    localparam int VW = 8;
    localparam int AW = 24;
    localparam int CW = $clog2(N + 1);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic                 in_ready;
    logic [VW-1:0]        in_data = '0;
    logic                 in_last = 1'b0;
    logic [N*VW-1:0]      line_wts = '0;
    logic                 out_done;
    logic signed [AW-1:0] out_sum;
    logic [CW-1:0]        out_nnz;
    logic [N-1:0]         out_map;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic signed [7:0] lv [N];
    logic signed [7:0] lw [N];

    sparse_line_mac #(.N(N), .VW(VW), .AW(AW), .CW(CW)) u_sparse_line_mac (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .line_wts(line_wts),
        .out_done(out_done), .out_sum(out_sum), .out_nnz(out_nnz), .out_map(out_map)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int dense_sum(input int len);
        int s = 0;
        for (int i = 0; i < len; i++) s += int'(lv[i]) * int'(lw[i]);
        return s;
    endfunction

    function automatic logic [N-1:0] dense_map(input int len);
        logic [N-1:0] m = '0;
        for (int i = 0; i < len; i++) m[i] = (lv[i] != 0);
        return m;
    endfunction

    // use_last = 0 requires len == N (R4 auto end)
    task automatic run_line(input int len, input bit use_last, input string tag);
        int exp_sum, exp_nnz, t0, guard;
        logic [N-1:0] exp_map;
        exp_sum = dense_sum(len);
        exp_map = dense_map(len);
        exp_nnz = $countones(exp_map);
        for (int i = 0; i < N; i++) line_wts[i*VW +: VW] = lw[i];
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = lv[i];
            in_last  = use_last && (i == len - 1);
            @(posedge clk);
        end
        @(negedge clk);
        t0 = cyc;
        // R9: garbage while busy must be ignored
        in_valid = 1'b1;
        in_data  = 8'h5A;
        in_last  = 1'b1;
        chk(in_ready == 1'b0, {"R7 ready low after line ", tag}, in_ready, 0);
        guard = 0;
        while (!out_done && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        in_data  = '0;
        chk(int'(out_sum) == exp_sum, {"R3 sum ", tag}, out_sum, exp_sum);
        chk(int'(out_nnz) == exp_nnz, {"R2 nnz ", tag}, out_nnz, exp_nnz);
        chk(out_map == exp_map, {"R1 map ", tag}, out_map, exp_map);
        chk(cyc - t0 == exp_nnz + 2, {"R5 latency ", tag}, cyc - t0, exp_nnz + 2);
        chk(in_ready == 1'b1, {"R7 ready in done cycle ", tag}, in_ready, 1);
        @(negedge clk);
        chk(out_done == 1'b0, {"R6 done pulse width ", tag}, out_done, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R7 reset ready", in_ready, 1);
        chk(out_done == 1'b0, "R7 reset done", out_done, 0);

        // R8: all zero full line
        for (int i = 0; i < N; i++) begin lv[i] = 0; lw[i] = 8'sd3; end
        run_line(N, 1'b1, "all-zero R8");

        // all nonzero extremes
        for (int i = 0; i < N; i++) begin lv[i] = -8'sd128; lw[i] = -8'sd128; end
        run_line(N, 1'b1, "all-nonzero max");

        // single nonzero at the last position, no in_last (R4 auto end)
        for (int i = 0; i < N; i++) begin lv[i] = 0; lw[i] = 8'(i + 1); end
        lv[N-1] = 8'sd7;
        run_line(N, 1'b0, "last-pos R4");

        // short line ended by in_last, one zero value
        lv[0] = 0;
        run_line(1, 1'b1, "len1-zero R4");

        // short line with mixed signs
        lv[0] = 8'sd5; lv[1] = 0; lv[2] = -8'sd9; lv[3] = 8'sd127;
        lw[0] = -8'sd2; lw[1] = 8'sd100; lw[2] = 8'sd11; lw[3] = -8'sd1;
        run_line(4, 1'b1, "short-mixed R4");

        // random lines
        for (int n = 0; n < 40; n++) begin
            int dens, len;
            bit ul;
            dens = int'($urandom_range(0, 4));
            ul   = (n % 3) != 0;
            len  = ul ? int'($urandom_range(1, N)) : N;
            for (int i = 0; i < N; i++) begin
                lw[i] = 8'($urandom);
                lv[i] = (int'($urandom_range(0, 3)) < dens) ? 8'($urandom_range(1, 255)) : 8'sd0;
            end
            run_line(len, ul, $sformatf("random%0d R3", n));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule